// File: doc/BRIEF.md
# Split Storage Boundary Address Controller

This block shares one physical storage array between two regions, program storage and microcode (control) storage. A movable boundary register splits them. Byte addresses below the boundary are program storage. Addresses equal to or above the boundary are control storage. Each cycle the block takes requests from three runtime sources: the trap/forced path, the local-storage data path and the microsequencer's control-word fetch. It grants one of them by fixed priority and forms the physical byte address. It suppresses any access that lands outside the region its source may touch.

After a hardware reset, and whenever the system-reset sequence is requested, the block performs its own boundary setup. It issues one read of a fixed word at the top of the array and holds off every other source. When the returned data arrives, it writes the boundary register. A boundary value that would leave the control region illegal is forced to the nearest legal value, and this is reported on a configuration-error output.

Top module: `stor_split_ctrl`

## Requirements
- R1: After reset is released, `busy` is 1 and no grant is given for one idle cycle. In the next cycle the block drives `mem_valid`=1 with `mem_addr` = top of array minus 4 (0x1FFFC by default). The boundary reads 0x18000 (32K of control storage) until the first load completes.
- R2: While waiting for the boundary read, a cycle with `rd_valid`=1 writes the adjusted boundary. In the following cycle `busy` is 0.
- R3: The loaded value is rounded to the nearest 2K multiple, with a half step rounding up. It is then clamped so that control storage stays between 32K and 64K bytes, which is boundary 0x10000..0x18000 by default. Any set bit of `rd_data` above the address width forces the upper limit. `cfg_err` is 1 exactly when the stored boundary differs from the raw value, and it holds until the next load.
- R4: In the run state, at most one of `trap_gnt`, `data_gnt`, `cw_gnt` is 1. The grant falls in the same cycle as the request. Priority is trap first, then data, then control word.
- R5: A granted trap request drives `mem_valid`=1 with `mem_addr`=`trap_addr`, with no region check.
- R6: A granted data request with `data_addr` below the boundary drives `mem_valid`=1 and `mem_addr`=`data_addr`. A granted data request at or above the boundary gives `addr_viol`=1 and `mem_valid`=0.
- R7: A granted control-word request addresses `boundary + 4*cw_word`. If that sum reaches or passes the top of the array, the access gives `addr_viol`=1 and `mem_valid`=0.
- R8: `sys_reset_req` in the run state blocks all grants in that cycle. In the next cycle the boundary read of R1 is issued, and `busy` stays 1 until R2 completes.
- R9: In the run state `rd_valid` is ignored, and the boundary changes only through a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_reset_req | input | 1 | Request to rerun the boundary load |
| trap_req | input | 1 | Forced/trap access request |
| trap_addr | input | ADDR_W | Absolute byte address of the trap access |
| data_req | input | 1 | Program-data access request from local storage |
| data_addr | input | ADDR_W | Program-data byte address |
| cw_req | input | 1 | Control-word fetch request |
| cw_word | input | CW_W | Control-word index, relative to the boundary |
| rd_valid | input | 1 | Read data valid from the array |
| rd_data | input | DATA_W | Read data from the array |
| trap_gnt | output | 1 | Trap request accepted this cycle |
| data_gnt | output | 1 | Data request accepted this cycle |
| cw_gnt | output | 1 | Control-word request accepted this cycle |
| mem_valid | output | 1 | Array access issued this cycle |
| mem_addr | output | ADDR_W | Physical byte address of the access |
| addr_viol | output | 1 | Accepted access was outside its region and was dropped |
| busy | output | 1 | Boundary load in progress; requests held off |
| boundary | output | ADDR_W | Current boundary byte address |
| cfg_err | output | 1 | Last loaded boundary had to be adjusted |

## Verification
Two functions can meet in one cycle. The first is arbitration with the region check. A data request whose address crosses the boundary can arrive while a lower-priority control-word fetch is pending. The bench presents both together and expects the data grant, a raised violation and no array access, with the fetch left ungranted. The second is a reload request with live traffic. The bench raises `sys_reset_req` while a fetch is pending. It expects no grant in that cycle, then the fixed-location read in the next cycle, and then the new boundary at the ports.

// File: rtl/stor_split_pkg.sv
package stor_split_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RUN   = 2'd3
    } ld_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_DATA = 2'd2,
        SRC_CW   = 2'd3
    } src_e;

endpackage

// File: rtl/stor_split_arb.sv
module stor_split_arb
    import stor_split_pkg::*;
(
    input  logic en,
    input  logic trap_req,
    input  logic data_req,
    input  logic cw_req,
    output src_e src,
    output logic trap_gnt,
    output logic data_gnt,
    output logic cw_gnt
);

    always_comb begin
        src = SRC_NONE;
        if (en) begin
            if (trap_req)      src = SRC_TRAP;
            else if (data_req) src = SRC_DATA;
            else if (cw_req)   src = SRC_CW;
        end
        trap_gnt = (src == SRC_TRAP);
        data_gnt = (src == SRC_DATA);
        cw_gnt   = (src == SRC_CW);
    end

endmodule

// File: rtl/stor_split_clamp.sv
module stor_split_clamp #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 32,
    parameter int CTRL_MIN = 32768,
    parameter int CTRL_MAX = 65536,
    parameter int STEP     = 2048
) (
    input  logic [DATA_W-1:0] raw,
    output logic [ADDR_W-1:0] bound,
    output logic              err
);

    localparam int MEM     = 1 << ADDR_W;
    localparam int AW1     = ADDR_W + 1;
    localparam int STEP_LG = $clog2(STEP);
    localparam logic [AW1-1:0] LO   = AW1'(MEM - CTRL_MAX);
    localparam logic [AW1-1:0] HI   = AW1'(MEM - CTRL_MIN);
    localparam logic [AW1-1:0] HALF = AW1'(STEP / 2);

    logic [AW1-1:0] rnd;
    logic           hi_bits;
    logic           over;
    logic           under;

    always_comb begin
        rnd                = {1'b0, raw[ADDR_W-1:0]} + HALF;
        rnd[STEP_LG-1:0]   = '0;
        hi_bits            = |raw[DATA_W-1:ADDR_W];
        over               = hi_bits || (rnd > HI);
        under              = !over && (rnd < LO);
        if (over)       bound = HI[ADDR_W-1:0];
        else if (under) bound = LO[ADDR_W-1:0];
        else            bound = rnd[ADDR_W-1:0];
        err = over || under || (rnd[ADDR_W-1:0] != raw[ADDR_W-1:0]);
    end

endmodule

// File: rtl/stor_split_region.sv
module stor_split_region #(
    parameter int ADDR_W = 17,
    parameter int CW_W   = 14,
    parameter int WB_LG  = 2
) (
    input  logic [ADDR_W-1:0] bnd,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [CW_W-1:0]   cw_word,
    output logic              data_viol,
    output logic [ADDR_W-1:0] cw_addr,
    output logic              cw_viol
);

    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0] phys;

    always_comb begin
        phys      = {1'b0, bnd} + (AW1'(cw_word) << WB_LG);
        cw_addr   = phys[ADDR_W-1:0];
        cw_viol   = phys[ADDR_W];
        data_viol = (data_addr >= bnd);
    end

endmodule

// File: rtl/stor_split_ctrl.sv
module stor_split_ctrl
    import stor_split_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 32,
    parameter int CTRL_MIN   = 32768,
    parameter int CTRL_MAX   = 65536,
    parameter int STEP       = 2048,
    parameter int WORD_BYTES = 4,
    parameter int CW_W       = $clog2(CTRL_MAX / WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset_req,
    input  logic              trap_req,
    input  logic [ADDR_W-1:0] trap_addr,
    input  logic              data_req,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              cw_req,
    input  logic [CW_W-1:0]   cw_word,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              trap_gnt,
    output logic              data_gnt,
    output logic              cw_gnt,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              addr_viol,
    output logic              busy,
    output logic [ADDR_W-1:0] boundary,
    output logic              cfg_err
);

    localparam int MEM     = 1 << ADDR_W;
    localparam int WB_LG   = $clog2(WORD_BYTES);
    localparam int STEP_LG = $clog2(STEP);
    localparam logic [ADDR_W-1:0] BOOT_LOC  = ADDR_W'(MEM - WORD_BYTES);
    localparam logic [ADDR_W-1:0] BND_LO    = ADDR_W'(MEM - CTRL_MAX);
    localparam logic [ADDR_W-1:0] BND_HI    = ADDR_W'(MEM - CTRL_MIN);

    typedef struct packed {
        ld_state_e         st;
        logic [ADDR_W-1:0] bnd;
        logic              cerr;
    } regs_t;

    regs_t r_q, r_d;

    src_e              src;
    logic              arb_en;
    logic [ADDR_W-1:0] clamp_bnd;
    logic              clamp_err;
    logic              data_viol;
    logic              cw_viol;
    logic [ADDR_W-1:0] cw_addr;

    assign arb_en = (r_q.st == ST_RUN) && !sys_reset_req;

    stor_split_arb u_arb (
        .en       (arb_en),
        .trap_req (trap_req),
        .data_req (data_req),
        .cw_req   (cw_req),
        .src      (src),
        .trap_gnt (trap_gnt),
        .data_gnt (data_gnt),
        .cw_gnt   (cw_gnt)
    );

    stor_split_clamp #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_MIN (CTRL_MIN),
        .CTRL_MAX (CTRL_MAX),
        .STEP     (STEP)
    ) u_clamp (
        .raw   (rd_data),
        .bound (clamp_bnd),
        .err   (clamp_err)
    );

    stor_split_region #(
        .ADDR_W (ADDR_W),
        .CW_W   (CW_W),
        .WB_LG  (WB_LG)
    ) u_region (
        .bnd       (r_q.bnd),
        .data_addr (data_addr),
        .cw_word   (cw_word),
        .data_viol (data_viol),
        .cw_addr   (cw_addr),
        .cw_viol   (cw_viol)
    );

    always_comb begin
        r_d       = r_q;
        mem_valid = 1'b0;
        mem_addr  = '0;
        addr_viol = 1'b0;
        case (r_q.st)
            ST_BOOT: begin
                r_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                mem_valid = 1'b1;
                mem_addr  = BOOT_LOC;
                r_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_valid) begin
                    r_d.bnd  = clamp_bnd;
                    r_d.cerr = clamp_err;
                    r_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (sys_reset_req) r_d.st = ST_ISSUE;
                case (src)
                    SRC_TRAP: begin
                        mem_valid = 1'b1;
                        mem_addr  = trap_addr;
                    end
                    SRC_DATA: begin
                        addr_viol = data_viol;
                        mem_valid = !data_viol;
                        mem_addr  = data_addr;
                    end
                    SRC_CW: begin
                        addr_viol = cw_viol;
                        mem_valid = !cw_viol;
                        mem_addr  = cw_addr;
                    end
                    default: begin
                        mem_valid = 1'b0;
                    end
                endcase
            end
            default: begin
                r_d.st = ST_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_BOOT;
            r_q.bnd  <= BND_HI;
            r_q.cerr <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_RUN);
    assign boundary = r_q.bnd;
    assign cfg_err  = r_q.cerr;

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(trap_gnt || data_gnt || cw_gnt)); // R1

    AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && rd_valid) |=> !busy); // R2

    AST_BOUND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary >= BND_LO) && (boundary <= BND_HI)
        && (boundary[STEP_LG-1:0] == '0)); // R3

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_gnt, data_gnt, cw_gnt})); // R4

    AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !busy && !sys_reset_req) |-> trap_gnt); // R4

    AST_DATA_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (data_gnt && data_addr >= boundary) |-> (addr_viol && !mem_valid)); // R6

    AST_CW_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_gnt && mem_valid) |-> (mem_addr >= boundary)); // R7

    AST_BOUND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sys_reset_req) |=> $stable(boundary)); // R9

endmodule

// File: tb/stor_split_ctrl_bench.sv
module stor_split_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_reset_req = 1'b0;
    logic        trap_req = 1'b0;
    logic [16:0] trap_addr = '0;
    logic        data_req = 1'b0;
    logic [16:0] data_addr = '0;
    logic        cw_req = 1'b0;
    logic [13:0] cw_word = '0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        trap_gnt, data_gnt, cw_gnt;
    logic        mem_valid, addr_viol, busy, cfg_err;
    logic [16:0] mem_addr, boundary;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    stor_split_ctrl u_stor_split_ctrl (
        .clk(clk), .rst_n(rst_n), .sys_reset_req(sys_reset_req),
        .trap_req(trap_req), .trap_addr(trap_addr),
        .data_req(data_req), .data_addr(data_addr),
        .cw_req(cw_req), .cw_word(cw_word),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .trap_gnt(trap_gnt), .data_gnt(data_gnt), .cw_gnt(cw_gnt),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .addr_viol(addr_viol),
        .busy(busy), .boundary(boundary), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic        tr;
        logic [16:0] ta;
        logic        dr;
        logic [16:0] da;
        logic        cr;
        logic [13:0] cw;
        logic [2:0]  eg;
        logic        ev;
        logic [16:0] ea;
        logic        ex;
    } vec_t;

    // run-state vectors, boundary 0x14000; eg = {trap,data,cw}
    localparam vec_t VEC [0:12] = '{
        '{1'b0, 17'h00000, 1'b0, 17'h00000, 1'b0, 14'h0000, 3'b000, 1'b0, 17'h00000, 1'b0},
        '{1'b0, 17'h00000, 1'b0, 17'h00000, 1'b1, 14'h0000, 3'b001, 1'b1, 17'h14000, 1'b0},
        '{1'b0, 17'h00000, 1'b0, 17'h00000, 1'b1, 14'h0010, 3'b001, 1'b1, 17'h14040, 1'b0},
        '{1'b0, 17'h00000, 1'b1, 17'h00100, 1'b0, 14'h0000, 3'b010, 1'b1, 17'h00100, 1'b0},
        '{1'b0, 17'h00000, 1'b1, 17'h13FFC, 1'b0, 14'h0000, 3'b010, 1'b1, 17'h13FFC, 1'b0},
        '{1'b0, 17'h00000, 1'b1, 17'h14000, 1'b0, 14'h0000, 3'b010, 1'b0, 17'h00000, 1'b1},
        '{1'b0, 17'h00000, 1'b1, 17'h02000, 1'b1, 14'h0005, 3'b010, 1'b1, 17'h02000, 1'b0},
        '{1'b0, 17'h00000, 1'b1, 17'h15000, 1'b1, 14'h0001, 3'b010, 1'b0, 17'h00000, 1'b1},
        '{1'b1, 17'h1F000, 1'b1, 17'h00100, 1'b1, 14'h0001, 3'b100, 1'b1, 17'h1F000, 1'b0},
        '{1'b1, 17'h00000, 1'b0, 17'h00000, 1'b1, 14'h0003, 3'b100, 1'b1, 17'h00000, 1'b0},
        '{1'b0, 17'h00000, 1'b0, 17'h00000, 1'b1, 14'h2FFF, 3'b001, 1'b1, 17'h1FFFC, 1'b0},
        '{1'b0, 17'h00000, 1'b0, 17'h00000, 1'b1, 14'h3000, 3'b001, 1'b0, 17'h00000, 1'b1},
        '{1'b0, 17'h00000, 1'b0, 17'h00000, 1'b1, 14'h3FFF, 3'b001, 1'b0, 17'h00000, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reload(input logic [31:0] val, input logic [16:0] exp_b,
                          input logic exp_e, input string tag);
        sys_reset_req = 1'b1;
        cw_req        = 1'b1;
        cw_word       = '0;
        #1;
        chk("R8", {tag, " grants on reload cycle"}, {trap_gnt, data_gnt, cw_gnt}, 3'b000);
        step();
        sys_reset_req = 1'b0;
        #1;
        chk("R8", {tag, " read issued"}, {mem_valid, mem_addr}, {1'b1, 17'h1FFFC});
        chk("R1", {tag, " fetch held off"}, cw_gnt, 1'b0);
        step();
        rd_valid = 1'b1;
        rd_data  = val;
        #1;
        chk("R8", {tag, " busy while waiting"}, busy, 1'b1);
        step();
        rd_valid = 1'b0;
        cw_req   = 1'b0;
        #1;
        chk("R2", {tag, " busy after load"}, busy, 1'b0);
        chk("R3", {tag, " boundary"}, boundary, exp_b);
        chk("R3", {tag, " cfg_err"}, cfg_err, exp_e);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        data_req = 1'b1;
        data_addr = 17'h00040;
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R1: idle cycle after reset
        chk("R1", "busy after reset", busy, 1'b1);
        chk("R1", "no access in boot cycle", mem_valid, 1'b0);
        chk("R1", "reset boundary", boundary, 17'h18000);
        chk("R1", "reset cfg_err", cfg_err, 1'b0);
        chk("R1", "no grant in boot", data_gnt, 1'b0);
        step();
        #1;
        chk("R1", "boot read", {mem_valid, mem_addr}, {1'b1, 17'h1FFFC});
        chk("R1", "no grant in issue", data_gnt, 1'b0);
        step();
        data_req = 1'b0;
        rd_valid = 1'b1;
        rd_data  = 32'h0001_4000;
        #1;
        chk("R1", "busy in wait", busy, 1'b1);
        chk("R1", "no access in wait", mem_valid, 1'b0);
        step();
        rd_valid = 1'b0;
        #1;
        chk("R2", "busy cleared", busy, 1'b0);
        chk("R2", "boundary loaded", boundary, 17'h14000);
        chk("R3", "legal value no error", cfg_err, 1'b0);

        // vector table: R4 priority, R5 trap, R6 data, R7 control word
        for (int i = 0; i < 13; i++) begin
            trap_req  = VEC[i].tr;
            trap_addr = VEC[i].ta;
            data_req  = VEC[i].dr;
            data_addr = VEC[i].da;
            cw_req    = VEC[i].cr;
            cw_word   = VEC[i].cw;
            #1;
            chk("R4", $sformatf("vec%0d grants", i), {trap_gnt, data_gnt, cw_gnt}, VEC[i].eg);
            chk(VEC[i].eg[2] ? "R5" : (VEC[i].eg[1] ? "R6" : "R7"),
                $sformatf("vec%0d valid/viol", i), {mem_valid, addr_viol}, {VEC[i].ev, VEC[i].ex});
            if (VEC[i].ev)
                chk(VEC[i].eg[2] ? "R5" : (VEC[i].eg[1] ? "R6" : "R7"),
                    $sformatf("vec%0d address", i), mem_addr, VEC[i].ea);
            step();
        end
        trap_req = 1'b0;
        data_req = 1'b0;
        cw_req   = 1'b0;

        // R9: stray read data in run state is ignored
        rd_valid = 1'b1;
        rd_data  = 32'h0001_0000;
        step();
        rd_valid = 1'b0;
        #1;
        chk("R9", "boundary kept", boundary, 17'h14000);
        chk("R9", "still running", busy, 1'b0);
        step();
        #1;
        chk("R9", "boundary kept later", boundary, 17'h14000);

        // R3 adjustment cases through R8 reload
        reload(32'h0001_4400, 17'h14800, 1'b1, "half step up");
        reload(32'h0001_43FF, 17'h14000, 1'b1, "below half");
        reload(32'h0000_8000, 17'h10000, 1'b1, "too low");
        reload(32'h0001_C000, 17'h18000, 1'b1, "too high");
        reload(32'h0002_0000, 17'h18000, 1'b1, "upper bits");
        reload(32'h0001_0000, 17'h10000, 1'b0, "low edge");
        reload(32'h0001_8000, 17'h18000, 1'b0, "high edge");
        reload(32'h0001_7C00, 17'h18000, 1'b1, "round to edge");
        reload(32'h0001_4000, 17'h14000, 1'b0, "restore");

        // R6 with the new boundary at the edge
        data_req  = 1'b1;
        data_addr = 17'h13FFF;
        #1;
        chk("R6", "last program byte", {mem_valid, addr_viol}, 2'b10);
        step();
        data_req = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule